// File: doc/BRIEF.md
# Unnormalized Double-Precision Multiplier Core

This block multiplies two IEEE 754 binary64 operands and stops before normalization and rounding. It delivers the sign, a widened signed exponent and the full double-width significand product. A separate normalizer and then a rounder take this output. Subnormal operands enter with a hidden bit of zero and an effective exponent of one, so they are multiplied as real values and never flushed. NaN, infinity and zero operands are classified, and the result carries a two-bit kind code so that special results are never mistaken for finite ones.

The core is a three-stage pipeline gated by a clock enable. The first stage registers the decoded operands. The second registers the special-case outcome and either the full product or two partial products, chosen by a parameter. The third registers the final product. A rounding-mode field has no effect on the arithmetic. It travels beside the data so that it reaches the rounder together with its own result.

Top module: `fp_mul_unnorm`

## Requirements
- R1: For every result whose kind is not NaN, `o_sign` is the XOR of the two operand sign bits (bit 63).
- R2: A normal operand contributes significand {1, fraction} and its stored exponent. A subnormal operand (exponent field 0, fraction nonzero) contributes {0, fraction} and effective exponent 1.
- R3: For finite results, `o_exp` is ea + eb - 1023 as a 13-bit two's-complement value, where ea and eb are the effective exponents.
- R4: For finite results, `o_sig` is the complete 106-bit product of the two 53-bit significands, with bits 105:104 as integer bits. It is never zero.
- R5: If either operand is a NaN (exponent field all ones, fraction nonzero), the result has kind 3, sign 0, exponent 2047, and `o_sig` has only bit 103 set.
- R6: Infinity times zero, in either operand order, gives the same NaN result as R5.
- R7: Infinity times a nonzero non-NaN value gives kind 2, exponent 2047, significand 0 and the sign from R1.
- R8: Zero times a finite value gives kind 1, exponent 0, significand 0 and the sign from R1. A finite nonzero product has kind 0.
- R9: `o_rm` presents the rounding mode that was sampled with the same operands.
- R10: A result appears after three enabled clock edges. While `ce` is low, every output holds its value, whatever the inputs do.
- R11: While reset is asserted, the outputs are kind 1, sign 0, exponent 0, significand 0 and mode 0.
- R12: After normalization and round-to-nearest-even of a finite output whose rounded exponent lies in 1..2046, the value equals the real-number product of the operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Clock enable; the pipeline moves only when high |
| i_a | input | 64 | First binary64 operand |
| i_b | input | 64 | Second binary64 operand |
| i_rm | input | 3 | Rounding mode carried to the output |
| o_sign | output | 1 | Product sign |
| o_exp | output | 13 | Biased product exponent, two's complement |
| o_sig | output | 106 | Unnormalized significand product, two integer bits |
| o_rm | output | 3 | Rounding mode aligned with the result |
| o_kind | output | 2 | 0 finite, 1 zero, 2 infinity, 3 NaN |

## Verification
The hardest situations to reach are the extremes of the widened exponent. A product of two subnormals drives the exponent negative (-1021) with a significand of only a few bits. Squaring the largest normal drives it to 3069. Neither can be represented in the operand format. Directed operand pairs produce both cases. Random pairs of a subnormal and a large normal give products that are back in normal range, where the bench normalizes and rounds the output and compares it against real multiplication. Enable gaps with junk on the inputs are inserted between operands, so that both the hold behaviour and the alignment of the mode field are exercised.

// File: rtl/fpmu_pkg.sv
package fpmu_pkg;

   // operand classification after field decode
   typedef enum logic [2:0] {
      CLS_ZERO = 3'd0,
      CLS_SUB  = 3'd1,
      CLS_NORM = 3'd2,
      CLS_INF  = 3'd3,
      CLS_NAN  = 3'd4
   } fpmu_cls_e;

   // result kind presented on o_kind
   typedef enum logic [1:0] {
      KIND_FIN  = 2'd0,
      KIND_ZERO = 2'd1,
      KIND_INF  = 2'd2,
      KIND_NAN  = 2'd3
   } fpmu_kind_e;

endpackage

// File: rtl/fpmu_decode.sv
module fpmu_decode
   import fpmu_pkg::*;
#(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52
) (
   input  logic [EXP_W+FRAC_W:0] op,
   output logic                  sign,
   output logic [EXP_W-1:0]      eff_exp,
   output logic [FRAC_W:0]       sig,
   output fpmu_cls_e             cls
);

   logic [EXP_W-1:0]  exp_field;
   logic [FRAC_W-1:0] frac_field;
   logic              exp_is_zero;
   logic              exp_is_ones;
   logic              frac_is_zero;

   assign sign         = op[EXP_W+FRAC_W];
   assign exp_field    = op[EXP_W+FRAC_W-1 -: EXP_W];
   assign frac_field   = op[FRAC_W-1:0];
   assign exp_is_zero  = (exp_field == '0);
   assign exp_is_ones  = &exp_field;
   assign frac_is_zero = (frac_field == '0);

   // subnormals keep their real value: hidden bit 0, exponent 1
   assign eff_exp = exp_is_zero ? EXP_W'(1) : exp_field;
   assign sig     = {~exp_is_zero, frac_field};

   always_comb begin
      if (exp_is_ones)
         cls = frac_is_zero ? CLS_INF : CLS_NAN;
      else if (exp_is_zero)
         cls = frac_is_zero ? CLS_ZERO : CLS_SUB;
      else
         cls = CLS_NORM;
   end

endmodule

// File: rtl/fpmu_special.sv
module fpmu_special
   import fpmu_pkg::*;
#(
   parameter int EXP_W     = 11,
   parameter int OUT_EXP_W = EXP_W + 2
) (
   input  logic                 sign_a,
   input  logic                 sign_b,
   input  fpmu_cls_e            cls_a,
   input  fpmu_cls_e            cls_b,
   input  logic [EXP_W-1:0]     exp_a,
   input  logic [EXP_W-1:0]     exp_b,
   output fpmu_kind_e           kind,
   output logic                 sign,
   output logic [OUT_EXP_W-1:0] exp_sum
);

   localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
   localparam int EXP_MAX = (1 << EXP_W) - 1;

   logic any_nan;
   logic any_inf;
   logic any_zero;
   logic [OUT_EXP_W-1:0] biased;

   assign any_nan  = (cls_a == CLS_NAN)  || (cls_b == CLS_NAN);
   assign any_inf  = (cls_a == CLS_INF)  || (cls_b == CLS_INF);
   assign any_zero = (cls_a == CLS_ZERO) || (cls_b == CLS_ZERO);

   // modular arithmetic in the widened field yields two's complement
   assign biased = OUT_EXP_W'(exp_a) + OUT_EXP_W'(exp_b) - OUT_EXP_W'(BIAS);

   always_comb begin
      kind    = KIND_FIN;
      sign    = sign_a ^ sign_b;
      exp_sum = biased;
      if (any_nan || (any_inf && any_zero)) begin
         kind    = KIND_NAN;
         sign    = 1'b0;
         exp_sum = OUT_EXP_W'(EXP_MAX);
      end else if (any_inf) begin
         kind    = KIND_INF;
         exp_sum = OUT_EXP_W'(EXP_MAX);
      end else if (any_zero) begin
         kind    = KIND_ZERO;
         exp_sum = '0;
      end
   end

endmodule

// File: rtl/fpmu_sigmul.sv
module fpmu_sigmul #(
   parameter int SIG_W = 53,
   parameter int SPLIT = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ce,
   input  logic [SIG_W-1:0]     sig_a,
   input  logic [SIG_W-1:0]     sig_b,
   output logic [2*SIG_W-1:0]   prod
);

   localparam int PROD_W = 2 * SIG_W;
   localparam int LO_W   = SIG_W / 2;
   localparam int HI_W   = SIG_W - LO_W;
   localparam int PLO_W  = SIG_W + LO_W;
   localparam int PHI_W  = SIG_W + HI_W;

   logic [PROD_W-1:0] prod_q;

   generate
      if (SPLIT == 1) begin : g_whole
         // one wide multiplier in stage two, plain register in stage three
         logic [PROD_W-1:0] full_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               full_q <= '0;
               prod_q <= '0;
            end else if (ce) begin
               full_q <= PROD_W'(sig_a) * PROD_W'(sig_b);
               prod_q <= full_q;
            end
         end
      end else begin : g_halves
         // two narrower multipliers in stage two, one adder in stage three
         logic [PLO_W-1:0] pp_lo_q;
         logic [PHI_W-1:0] pp_hi_q;
         logic [LO_W-1:0]  b_lo;
         logic [HI_W-1:0]  b_hi;
         assign b_lo = sig_b[LO_W-1:0];
         assign b_hi = sig_b[SIG_W-1:LO_W];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pp_lo_q <= '0;
               pp_hi_q <= '0;
               prod_q  <= '0;
            end else if (ce) begin
               pp_lo_q <= PLO_W'(sig_a) * PLO_W'(b_lo);
               pp_hi_q <= PHI_W'(sig_a) * PHI_W'(b_hi);
               prod_q  <= {pp_hi_q, LO_W'(0)} + PROD_W'(pp_lo_q);
            end
         end
      end
   endgenerate

   assign prod = prod_q;

endmodule

// File: rtl/fp_mul_unnorm.sv
module fp_mul_unnorm
   import fpmu_pkg::*;
#(
   parameter int EXP_W     = 11,
   parameter int FRAC_W    = 52,
   parameter int RM_W      = 3,
   parameter int OUT_EXP_W = EXP_W + 2,
   parameter int SPLIT     = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ce,
   input  logic [EXP_W+FRAC_W:0]      i_a,
   input  logic [EXP_W+FRAC_W:0]      i_b,
   input  logic [RM_W-1:0]            i_rm,
   output logic                       o_sign,
   output logic [OUT_EXP_W-1:0]       o_exp,
   output logic [2*(FRAC_W+1)-1:0]    o_sig,
   output logic [RM_W-1:0]            o_rm,
   output logic [1:0]                 o_kind
);

   localparam int OP_W    = 1 + EXP_W + FRAC_W;
   localparam int SIG_W   = FRAC_W + 1;
   localparam int PROD_W  = 2 * SIG_W;
   localparam int QNAN_BIT = PROD_W - 3;

   // elaboration-time parameter checks
   generate
      if (SPLIT != 1 && SPLIT != 2) begin : g_bad_split
         $error("fp_mul_unnorm: SPLIT must be 1 or 2");
      end
      if (OUT_EXP_W < EXP_W + 2) begin : g_bad_exp_w
         $error("fp_mul_unnorm: OUT_EXP_W needs two bits over EXP_W");
      end
      if (EXP_W < 3 || FRAC_W < 2) begin : g_bad_fmt
         $error("fp_mul_unnorm: operand format too narrow");
      end
   endgenerate

   // ---------------- operand decode (combinational) ----------------
   logic [1:0][OP_W-1:0]  ops;
   logic [1:0]            sgn_d;
   logic [1:0][EXP_W-1:0] exp_d;
   logic [1:0][SIG_W-1:0] sig_d;
   fpmu_cls_e             cls_d [2];

   assign ops[0] = i_a;
   assign ops[1] = i_b;

   generate
      for (genvar g = 0; g < 2; g++) begin : g_dec
         fpmu_decode #(
            .EXP_W  (EXP_W),
            .FRAC_W (FRAC_W)
         ) u_dec (
            .op      (ops[g]),
            .sign    (sgn_d[g]),
            .eff_exp (exp_d[g]),
            .sig     (sig_d[g]),
            .cls     (cls_d[g])
         );
      end
   endgenerate

   // ---------------- stage one: decoded operands ----------------
   logic [1:0]            sgn_q1;
   logic [1:0][EXP_W-1:0] exp_q1;
   logic [1:0][SIG_W-1:0] sig_q1;
   fpmu_cls_e             cls_q1 [2];
   logic [RM_W-1:0]       rm_q1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sgn_q1    <= '0;
         exp_q1    <= '0;
         sig_q1    <= '0;
         cls_q1[0] <= CLS_ZERO;
         cls_q1[1] <= CLS_ZERO;
         rm_q1     <= '0;
      end else if (ce) begin
         sgn_q1    <= sgn_d;
         exp_q1    <= exp_d;
         sig_q1    <= sig_d;
         cls_q1[0] <= cls_d[0];
         cls_q1[1] <= cls_d[1];
         rm_q1     <= i_rm;
      end
   end

   // ---------------- special-case resolution ----------------
   fpmu_kind_e           kind_s;
   logic                 sign_s;
   logic [OUT_EXP_W-1:0] exp_s;

   fpmu_special #(
      .EXP_W     (EXP_W),
      .OUT_EXP_W (OUT_EXP_W)
   ) u_special (
      .sign_a  (sgn_q1[0]),
      .sign_b  (sgn_q1[1]),
      .cls_a   (cls_q1[0]),
      .cls_b   (cls_q1[1]),
      .exp_a   (exp_q1[0]),
      .exp_b   (exp_q1[1]),
      .kind    (kind_s),
      .sign    (sign_s),
      .exp_sum (exp_s)
   );

   // ---------------- significand product (stages two and three) ----------------
   logic [PROD_W-1:0] prod_q3;

   fpmu_sigmul #(
      .SIG_W (SIG_W),
      .SPLIT (SPLIT)
   ) u_sigmul (
      .clk   (clk),
      .rst_n (rst_n),
      .ce    (ce),
      .sig_a (sig_q1[0]),
      .sig_b (sig_q1[1]),
      .prod  (prod_q3)
   );

   // ---------------- stages two and three: side-band fields ----------------
   fpmu_kind_e           kind_q2, kind_q3;
   logic                 sign_q2, sign_q3;
   logic [OUT_EXP_W-1:0] exp_q2,  exp_q3;
   logic [RM_W-1:0]      rm_q2,   rm_q3;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q2 <= KIND_ZERO;
         sign_q2 <= 1'b0;
         exp_q2  <= '0;
         rm_q2   <= '0;
         kind_q3 <= KIND_ZERO;
         sign_q3 <= 1'b0;
         exp_q3  <= '0;
         rm_q3   <= '0;
      end else if (ce) begin
         kind_q2 <= kind_s;
         sign_q2 <= sign_s;
         exp_q2  <= exp_s;
         rm_q2   <= rm_q1;
         kind_q3 <= kind_q2;
         sign_q3 <= sign_q2;
         exp_q3  <= exp_q2;
         rm_q3   <= rm_q2;
      end
   end

   // ---------------- output selection ----------------
   always_comb begin
      case (kind_q3)
         KIND_FIN: o_sig = prod_q3;
         KIND_NAN: o_sig = PROD_W'(1) << QNAN_BIT;
         default:  o_sig = '0;
      endcase
   end

   assign o_sign = sign_q3;
   assign o_exp  = exp_q3;
   assign o_rm   = rm_q3;
   assign o_kind = kind_q3;

endmodule

// File: rtl/fp_mul_unnorm_chk.sv
module fp_mul_unnorm_chk #(
   parameter int EXP_W     = 11,
   parameter int FRAC_W    = 52,
   parameter int RM_W      = 3,
   parameter int OUT_EXP_W = EXP_W + 2,
   parameter int SPLIT     = 2
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    ce,
   input logic [EXP_W+FRAC_W:0]   i_a,
   input logic [EXP_W+FRAC_W:0]   i_b,
   input logic [RM_W-1:0]         i_rm,
   input logic                    o_sign,
   input logic [OUT_EXP_W-1:0]    o_exp,
   input logic [2*(FRAC_W+1)-1:0] o_sig,
   input logic [RM_W-1:0]         o_rm,
   input logic [1:0]              o_kind
);

   localparam int OP_W    = 1 + EXP_W + FRAC_W;
   localparam int PROD_W  = 2 * (FRAC_W + 1);
   localparam int EXP_MAX = (1 << EXP_W) - 1;

   // cycles since reset release, saturating at three
   logic [1:0] since_rst;
   logic       warm;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         since_rst <= '0;
      else if (since_rst != 2'd3)
         since_rst <= since_rst + 2'd1;
   end
   assign warm = (since_rst == 2'd3);

   logic a_inf, b_inf, a_zero, b_zero, inf_zero;
   assign a_inf    = (&i_a[OP_W-2 -: EXP_W]) && (i_a[FRAC_W-1:0] == '0);
   assign b_inf    = (&i_b[OP_W-2 -: EXP_W]) && (i_b[FRAC_W-1:0] == '0);
   assign a_zero   = (i_a[OP_W-2:0] == '0);
   assign b_zero   = (i_b[OP_W-2:0] == '0);
   assign inf_zero = (a_inf && b_zero) || (a_zero && b_inf);

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ce |=> ($stable(o_sig) && $stable(o_exp) && $stable(o_kind)
               && $stable(o_sign) && $stable(o_rm)));

   // R9
   rm_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && ce && $past(ce) && $past(ce, 2)) |=> (o_rm == $past(i_rm, 3)));

   // R1
   sign_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && ce && $past(ce) && $past(ce, 2)) |=>
      ((o_kind == 2'd3) || (o_sign == $past(i_a[OP_W-1] ^ i_b[OP_W-1], 3))));

   // R6
   inf_zero_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && ce && $past(ce) && $past(ce, 2)) |=> (!$past(inf_zero, 3) || (o_kind == 2'd3)));

   // R5
   nan_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (o_kind == 2'd3) |-> (!o_sign && (o_exp == OUT_EXP_W'(EXP_MAX))
                            && (o_sig == (PROD_W'(1) << (PROD_W - 3)))));

   // R7
   inf_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (o_kind == 2'd2) |-> ((o_exp == OUT_EXP_W'(EXP_MAX)) && (o_sig == '0)));

   // R8
   zero_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (o_kind == 2'd1) |-> ((o_exp == '0) && (o_sig == '0)));

   // R4
   finite_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (o_kind == 2'd0) |-> (o_sig != '0));

endmodule

bind fp_mul_unnorm fp_mul_unnorm_chk #(
   .EXP_W     (EXP_W),
   .FRAC_W    (FRAC_W),
   .RM_W      (RM_W),
   .OUT_EXP_W (OUT_EXP_W),
   .SPLIT     (SPLIT)
) u_chk (.*);

// File: tb/tb_fp_mul_unnorm.sv
`timescale 1ns / 1ps
module tb_fp_mul_unnorm;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ce = 1'b0;
   logic [63:0]  a = '0;
   logic [63:0]  b = '0;
   logic [2:0]   rm = '0;
   logic         o_sign;
   logic [12:0]  o_exp;
   logic [105:0] o_sig;
   logic [2:0]   o_rm;
   logic [1:0]   o_kind;

   always #5 clk = ~clk;

   fp_mul_unnorm dut (
      .clk(clk), .rst_n(rst_n), .ce(ce), .i_a(a), .i_b(b), .i_rm(rm),
      .o_sign(o_sign), .o_exp(o_exp), .o_sig(o_sig), .o_rm(o_rm), .o_kind(o_kind)
   );

   typedef struct packed {
      logic [63:0]  a;
      logic [63:0]  b;
      logic [2:0]   rm;
      logic         sign;
      logic [1:0]   kind;
      logic [12:0]  ex;
      logic [105:0] sig;
   } item_t;

   item_t q[$];
   int    checks = 0;
   int    errors = 0;
   bit    done = 0;

   task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, expv);
      end
   endtask

   // expected result from the requirements
   function automatic item_t model(input logic [63:0] xa, input logic [63:0] xb, input logic [2:0] xr);
      item_t e;
      logic [10:0] ea, eb;
      logic [51:0] fa, fb;
      logic [52:0] ma, mb;
      logic [10:0] ka, kb;
      logic a_nan, b_nan, a_inf, b_inf, a_zero, b_zero;
      ea = xa[62:52]; fa = xa[51:0];
      eb = xb[62:52]; fb = xb[51:0];
      a_nan = (&ea) && (fa != 0);  b_nan = (&eb) && (fb != 0);
      a_inf = (&ea) && (fa == 0);  b_inf = (&eb) && (fb == 0);
      a_zero = (ea == 0) && (fa == 0);
      b_zero = (eb == 0) && (fb == 0);
      ma = {ea != 0, fa};  mb = {eb != 0, fb};            // R2
      ka = (ea == 0) ? 11'd1 : ea;
      kb = (eb == 0) ? 11'd1 : eb;
      e.a = xa; e.b = xb; e.rm = xr;
      e.sign = xa[63] ^ xb[63];
      e.ex = '0; e.sig = '0;
      if (a_nan || b_nan || ((a_inf || b_inf) && (a_zero || b_zero))) begin
         e.kind = 2'd3; e.sign = 1'b0; e.ex = 13'd2047; e.sig = 106'd1 << 103;
      end else if (a_inf || b_inf) begin
         e.kind = 2'd2; e.ex = 13'd2047;
      end else if (a_zero || b_zero) begin
         e.kind = 2'd1;
      end else begin
         e.kind = 2'd0;
         e.ex   = 13'(ka) + 13'(kb) - 13'd1023;
         e.sig  = 106'(ma) * 106'(mb);
      end
      return e;
   endfunction

   function automatic string kind_req(input item_t e);
      if (e.kind == 2'd3)
         return ((&e.a[62:52]) && (e.a[51:0] != 0)) || ((&e.b[62:52]) && (e.b[51:0] != 0))
                ? "R5 nan kind" : "R6 inf*zero kind";
      if (e.kind == 2'd2) return "R7 inf kind";
      return "R8 zero/finite kind";
   endfunction

   // reference normalization and round-to-nearest-even of the output
   function automatic logic [64:0] norm_round(input logic s, input logic [12:0] e_in, input logic [105:0] sg);
      logic [105:0] m;
      logic [53:0]  man;
      logic         g, st;
      int           e;
      m = sg;
      e = int'($signed(e_in));
      if (m == 0) return '0;
      if (m[105]) begin
         man = {1'b0, m[105:53]}; g = m[52]; st = |m[51:0]; e = e + 1;
      end else begin
         while (!m[104]) begin m = m << 1; e = e - 1; end
         man = {1'b0, m[104:52]}; g = m[51]; st = |m[50:0];
      end
      if (g && (st || man[0])) man = man + 54'd1;
      if (man[53]) begin man = man >> 1; e = e + 1; end
      if (e < 1 || e > 2046) return '0;
      return {1'b1, s, e[10:0], man[51:0]};
   endfunction

   // bench-side tracking of enabled edges
   logic       drv_v = 1'b0;
   logic [2:0] vp = '0;
   logic       fresh = 1'b0;
   always @(posedge clk) begin
      if (!rst_n) begin
         vp    <= '0;
         fresh <= 1'b0;
      end else begin
         fresh <= ce;
         if (ce) vp <= {vp[1:0], drv_v};
      end
   end

   // monitor
   logic [127:0] last_out;
   bit           have_last = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (fresh && vp[2]) begin
            if (q.size() == 0) begin
               chk(1'b0, "R10 unexpected result", 128'(o_kind), 128'd0);
            end else begin
               item_t e;
               logic [64:0] r;
               logic [63:0] rb;
               e = q.pop_front();
               chk(o_kind == e.kind, kind_req(e), 128'(o_kind), 128'(e.kind));
               if (e.kind != 2'd3)
                  chk(o_sign == e.sign, "R1 sign", 128'(o_sign), 128'(e.sign));
               chk(o_exp == e.ex, "R2 R3 exponent", 128'(o_exp), 128'(e.ex));
               chk(o_sig == e.sig, "R4 significand", 128'(o_sig), 128'(e.sig));
               chk(o_rm == e.rm, "R9 mode", 128'(o_rm), 128'(e.rm));
               r = norm_round(o_sign, o_exp, o_sig);
               if (o_kind == 2'd0 && r[64]) begin
                  rb = $realtobits($bitstoreal(e.a) * $bitstoreal(e.b));
                  chk(r[63:0] == rb, "R12 rounded value", 128'(r[63:0]), 128'(rb));
               end
            end
         end else if (!fresh && have_last) begin
            chk({o_kind, o_sign, o_exp, o_sig, o_rm} == last_out[124:0], "R10 hold", 128'(last_out[124:0]), 128'({o_kind, o_sign, o_exp, o_sig, o_rm}));
         end
         last_out  = 128'({o_kind, o_sign, o_exp, o_sig, o_rm});
         have_last = 1;
      end
   end

   // driver: one operand pair, then idle cycles with junk inputs
   task automatic push(input logic [63:0] xa, input logic [63:0] xb, input logic [2:0] xr, input int gap);
      @(negedge clk);
      a = xa; b = xb; rm = xr; ce = 1'b1; drv_v = 1'b1;
      q.push_back(model(xa, xb, xr));
      for (int i = 0; i < gap; i++) begin
         @(negedge clk);
         ce = 1'b0; drv_v = 1'b0;
         a = {$urandom, $urandom}; b = {$urandom, $urandom}; rm = 3'($urandom);
      end
   endtask

   function automatic logic [63:0] rnd_norm(input int lo, input int hi);
      return {1'($urandom), 11'($urandom_range(hi, lo)), 20'($urandom), 32'($urandom)};
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      // R11
      chk(o_kind == 2'd1 && !o_sign && o_exp == 0 && o_sig == 0 && o_rm == 0,
          "R11 reset state", 128'({o_kind, o_sign, o_exp, o_sig, o_rm}), 128'({2'd1, 122'd0}));
      rst_n = 1'b1;
      push(64'h3FF8000000000000, 64'h3FF8000000000000, 3'd1, 0);  // 1.5*1.5
      push(64'h4000000000000000, 64'hC008000000000000, 3'd2, 1);  // 2*-3
      push(64'h0000000000000001, 64'h0000000000000001, 3'd3, 0);  // R2 min sub squared
      push(64'h7FEFFFFFFFFFFFFF, 64'h7FEFFFFFFFFFFFFF, 3'd4, 2);  // R3 max normal squared
      push(64'h000FFFFFFFFFFFFF, 64'h4330000000000000, 3'd5, 0);  // R2 sub*normal
      push(64'h7FF8000000000001, 64'h3FF0000000000000, 3'd6, 0);  // R5
      push(64'h3FF0000000000000, 64'hFFF0000000000001, 3'd7, 1);  // R5 other side
      push(64'h7FF0000000000000, 64'h0000000000000000, 3'd0, 0);  // R6
      push(64'h8000000000000000, 64'hFFF0000000000000, 3'd1, 0);  // R6 reversed
      push(64'h7FF0000000000000, 64'hC008000000000000, 3'd2, 0);  // R7
      push(64'h0000000000000005, 64'hFFF0000000000000, 3'd3, 0);  // R7 sub*-inf
      push(64'h8000000000000000, 64'h4014000000000000, 3'd4, 1);  // R8
      push(64'h8000000000000000, 64'h8000000000000000, 3'd5, 0);  // R8 -0*-0
      push(64'h000ABCDEF0123456, 64'h0000000000000000, 3'd6, 0);  // R8 sub*0
      for (int i = 0; i < 60; i++)
         push(rnd_norm(700, 1300), rnd_norm(700, 1300), 3'($urandom), $urandom_range(2, 0));
      for (int i = 0; i < 30; i++)
         push({1'($urandom), 11'd0, 20'($urandom), 32'($urandom)}, rnd_norm(1100, 2040),
              3'($urandom), $urandom_range(1, 0));
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         ce = 1'b1; drv_v = 1'b0;
      end
      @(negedge clk);
      ce = 1'b0;
      repeat (4) @(negedge clk);
      chk(q.size() == 0, "R10 all results drained", 128'(q.size()), 128'd0);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule